// File: doc/BRIEF.md
# Redundant Bus Receiver Diagnosis and Source Selector

This block sits between three receivers on a two-wire bus and the receive logic. It decides which receiver feeds the receive logic. The first receiver is differential. The second watches only the true wire. The third watches only the complement wire. Each receiver delivers the logical bit value, so all three agree when the bus is healthy.

A 2-bit mode input selects the source. Three mode codes force one receiver. The fourth code hands the choice to an automatic diagnosis machine, which uses two checks:

- **Edge check.** In every diagnosis period it counts transitions on each input.
- **Echo check.** While the node itself transmits, it compares the two single-ended receivers against the transmitted bit on each rising (dominant-to-recessive) transmit edge.

A failure on either check moves reception to a healthy wire, or into a major-error state. The current choice is reported on a 2-bit status output.

The diagnosis period is a power of two set by a 4-bit code. It should be programmed longer than the largest gap between frames anywhere on the network, so that a quiet bus is not mistaken for a broken one. Recessive is logic 1.

Top module: `ldiag_selector`

## Requirements
- R1: With mode 00 the output follows the differential input and the status reads 00.
- R2: With mode 01 the output follows the complement-wire input and the status reads 01. With mode 10 the output follows the true-wire input and the status reads 10.
- R3: With mode 11, the source follows the status: 00 → differential input, 01 → complement input, 10 → true input, 11 → differential input. The selected input appears on the output one clock after it is sampled.
- R4: The diagnosis period lasts 2^(code+6) clocks, so code 0 gives 64 clocks and code 0111 gives 8192 clocks. Edges sampled on the period's last clock still count.
- R5: In mode 11, at the end of a period, the status goes to 11 if the input in use (status 00, 01 or 10) showed fewer than 4 edges in that period. With 4 or more edges the status is unchanged.
- R6: In mode 11 with status 11, at the end of a period the status goes to 10 if the true input showed at least 4 edges. Otherwise it goes to 01 if the complement input did. Otherwise it stays 11.
- R7: In mode 11, an echo check takes place on each clock where the transmit-active flag is high and the transmit bit has just risen from 0 to 1. On a check:
  - From status 00: only the true input differing from the transmit bit gives 01; only the complement input differing gives 10; both differing gives 11.
  - From status 01 or 10: the wire in use differing gives 11.
  - An echo mismatch wins over a period end on the same clock.
- R8: A rising transmit edge has no effect on the status while the transmit-active flag is low, and in modes 00, 01 and 10.
- R9: A change of mode sets the status to the new mode's value (mode 11 → 00) on the next clock. It also restarts the diagnosis period and clears all edge counts.
- R10: Reset sets the status to 00 and the output to 1 (recessive).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_diff | input | 1 | Differential receiver bit |
| rx_true | input | 1 | True-wire receiver bit |
| rx_comp | input | 1 | Complement-wire receiver bit (logical value) |
| tx_data | input | 1 | Bit this node drives onto the bus |
| tx_active | input | 1 | High while this node transmits |
| mode | input | 2 | Source mode: 00 differential, 01 complement, 10 true, 11 automatic |
| period_sel | input | SEL_W | Diagnosis period code |
| rx_sel | output | 1 | Registered selected receive bit |
| diag_status | output | 2 | 00 normal, 01 on complement wire, 10 on true wire, 11 major error |

## Verification
The assertions check, on every clock, the following:
- a forced mode sets the status;
- the output tracks the complement input while that source is in use;
- entering automatic mode starts from status 00;
- a single complement-wire echo mismatch moves status 00 to 10;
- with no period end and no transmission, the status holds.

The rest can only be shown by the bench's scenarios:
- the edge thresholds at exactly 3 and 4 edges;
- the true-before-complement recovery order;
- the off-by-one period lengths for codes 0, 1 and 7;
- the full echo decision table.

// File: rtl/ldiag_pkg.sv
package ldiag_pkg;

  typedef enum logic [1:0] {
    ST_NORM  = 2'b00,
    ST_COMP  = 2'b01,
    ST_TRUE  = 2'b10,
    ST_MAJOR = 2'b11
  } diag_e;

  localparam int NUM_SRC  = 3;
  localparam int SRC_DIFF = 0;
  localparam int SRC_TRUE = 1;
  localparam int SRC_COMP = 2;

  localparam logic [1:0] MODE_AUTO = 2'b11;

endpackage

// File: rtl/ldiag_period_timer.sv
module ldiag_period_timer #(
  parameter int SEL_W      = 4,
  parameter int BASE_SHIFT = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);

  localparam int CNT_W = BASE_SHIFT + (1 << SEL_W);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] last;
  logic             at_end;

  // last count of a period of 2^(sel+BASE_SHIFT) clocks
  always_comb begin
    last   = (ONE << (BASE_SHIFT + int'(sel))) - ONE;
    at_end = (cnt >= last);
  end

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      cnt <= '0;
    end else if (at_end) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + ONE;
    end
  end

  assign tick = at_end && !restart;

endmodule

// File: rtl/ldiag_edge_counter.sv
module ldiag_edge_counter #(
  parameter int SAT = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic din,
  output logic enough
);

  localparam int CW = $clog2(SAT + 1);
  localparam logic [CW-1:0] SAT_V = CW'(SAT);

  logic          prev;
  logic [CW-1:0] cnt;
  logic [CW-1:0] cnt_inc;
  logic          edge_now;

  always_comb begin
    edge_now = din ^ prev;
    cnt_inc  = cnt;
    if (edge_now && (cnt < SAT_V)) begin
      cnt_inc = cnt + CW'(1);
    end
    enough = (cnt_inc >= SAT_V);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev <= 1'b1;
      cnt  <= '0;
    end else begin
      prev <= din;
      cnt  <= clear ? '0 : cnt_inc;
    end
  end

endmodule

// File: rtl/ldiag_echo_check.sv
module ldiag_echo_check (
  input  logic clk,
  input  logic rst,
  input  logic tx_data,
  input  logic tx_active,
  input  logic rx_true,
  input  logic rx_comp,
  output logic sample,
  output logic true_bad,
  output logic comp_bad
);

  logic tx_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_prev <= 1'b1;
    end else begin
      tx_prev <= tx_data;
    end
  end

  always_comb begin
    sample   = tx_active && tx_data && !tx_prev;
    true_bad = sample && (rx_true != tx_data);
    comp_bad = sample && (rx_comp != tx_data);
  end

endmodule

// File: rtl/ldiag_selector.sv
module ldiag_selector
  import ldiag_pkg::*;
#(
  parameter int SEL_W      = 4,
  parameter int BASE_SHIFT = 6,
  parameter int EDGE_MIN   = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rx_diff,
  input  logic             rx_true,
  input  logic             rx_comp,
  input  logic             tx_data,
  input  logic             tx_active,
  input  logic [1:0]       mode,
  input  logic [SEL_W-1:0] period_sel,
  output logic             rx_sel,
  output logic [1:0]       diag_status
);

  logic [1:0]         mode_q;
  logic               mode_chg;
  logic               period_tick;
  logic               echo_sample;
  logic               t_bad;
  logic               c_bad;
  logic [NUM_SRC-1:0] src_vec;
  logic [NUM_SRC-1:0] src_ok;
  diag_e              st_q;
  diag_e              st_n;

  assign mode_chg = (mode != mode_q);

  always_comb begin
    src_vec           = '0;
    src_vec[SRC_DIFF] = rx_diff;
    src_vec[SRC_TRUE] = rx_true;
    src_vec[SRC_COMP] = rx_comp;
  end

  ldiag_period_timer #(
    .SEL_W      (SEL_W),
    .BASE_SHIFT (BASE_SHIFT)
  ) u_timer (
    .clk     (clk),
    .rst     (rst),
    .restart (mode_chg),
    .sel     (period_sel),
    .tick    (period_tick)
  );

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_edge
    ldiag_edge_counter #(
      .SAT (EDGE_MIN)
    ) u_cnt (
      .clk    (clk),
      .rst    (rst),
      .clear  (period_tick || mode_chg),
      .din    (src_vec[g]),
      .enough (src_ok[g])
    );
  end

  ldiag_echo_check u_echo (
    .clk       (clk),
    .rst       (rst),
    .tx_data   (tx_data),
    .tx_active (tx_active),
    .rx_true   (rx_true),
    .rx_comp   (rx_comp),
    .sample    (echo_sample),
    .true_bad  (t_bad),
    .comp_bad  (c_bad)
  );

  // next diagnosis state
  always_comb begin
    st_n = st_q;
    if (mode != MODE_AUTO) begin
      st_n = diag_e'(mode);
    end else if (mode_chg) begin
      st_n = ST_NORM;
    end else if (t_bad || c_bad) begin
      unique case (st_q)
        ST_NORM: begin
          if (t_bad && c_bad) st_n = ST_MAJOR;
          else if (t_bad)     st_n = ST_COMP;
          else                st_n = ST_TRUE;
        end
        ST_COMP:  if (c_bad) st_n = ST_MAJOR;
        ST_TRUE:  if (t_bad) st_n = ST_MAJOR;
        default:  st_n = st_q;
      endcase
    end else if (period_tick) begin
      unique case (st_q)
        ST_NORM:  if (!src_ok[SRC_DIFF]) st_n = ST_MAJOR;
        ST_COMP:  if (!src_ok[SRC_COMP]) st_n = ST_MAJOR;
        ST_TRUE:  if (!src_ok[SRC_TRUE]) st_n = ST_MAJOR;
        default: begin
          if (src_ok[SRC_TRUE])      st_n = ST_TRUE;
          else if (src_ok[SRC_COMP]) st_n = ST_COMP;
          else                       st_n = ST_MAJOR;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= mode;
      st_q   <= ST_NORM;
      rx_sel <= 1'b1;
    end else begin
      mode_q <= mode;
      st_q   <= st_n;
      unique case (st_q)
        ST_COMP: rx_sel <= rx_comp;
        ST_TRUE: rx_sel <= rx_true;
        default: rx_sel <= rx_diff;
      endcase
    end
  end

  assign diag_status = st_q;

endmodule

// File: rtl/ldiag_selector_chk.sv
module ldiag_selector_chk (
  input logic       clk,
  input logic       rst,
  input logic [1:0] mode,
  input logic [1:0] mode_q,
  input logic [1:0] diag_status,
  input logic       rx_sel,
  input logic       rx_comp,
  input logic       rx_true,
  input logic       tx_data,
  input logic       tx_active,
  input logic       period_tick,
  input logic       echo_sample
);

  // R1
  // R2
  forced_mode_status_chk: assert property (@(posedge clk) disable iff (rst)
    (mode != 2'b11) |=> (diag_status == $past(mode)));

  // R3
  comp_source_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b11 && diag_status == 2'b01) |=> (rx_sel == $past(rx_comp)));

  // R9
  auto_entry_normal_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b11 && mode_q != 2'b11) |=> (diag_status == 2'b00));

  // R7
  comp_echo_fallback_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b11 && mode_q == 2'b11 && diag_status == 2'b00 && echo_sample
     && rx_true == tx_data && rx_comp != tx_data) |=> (diag_status == 2'b10));

  // R8
  quiet_status_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b11 && mode_q == 2'b11 && !period_tick && !tx_active)
      |=> $stable(diag_status));

endmodule

bind ldiag_selector ldiag_selector_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .mode        (mode),
  .mode_q      (mode_q),
  .diag_status (diag_status),
  .rx_sel      (rx_sel),
  .rx_comp     (rx_comp),
  .rx_true     (rx_true),
  .tx_data     (tx_data),
  .tx_active   (tx_active),
  .period_tick (period_tick),
  .echo_sample (echo_sample)
);

// File: tb/ldiag_selector_bench.sv
module ldiag_selector_bench;

  localparam int CLK_PERIOD = 10;
  localparam int BASE_LEN   = 64;
  localparam int SRC_NONE   = -1;
  localparam int SRC_D      = 0;
  localparam int SRC_T      = 1;
  localparam int SRC_C      = 2;

  logic       clk = 1'b0;
  logic       rst;
  logic       d, t, c, txd, txa;
  logic [1:0] mode;
  logic [3:0] psel;
  logic       rx_sel;
  logic [1:0] diag;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ldiag_selector u_ldiag_selector (
    .clk         (clk),
    .rst         (rst),
    .rx_diff     (d),
    .rx_true     (t),
    .rx_comp     (c),
    .tx_data     (txd),
    .tx_active   (txa),
    .mode        (mode),
    .period_sel  (psel),
    .rx_sel      (rx_sel),
    .diag_status (diag)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // leave automatic mode through mode 01, then return: period restarts
  task automatic enter_auto();
    @(negedge clk);
    mode = 2'b01; d = 1'b1; t = 1'b1; c = 1'b1; txd = 1'b1; txa = 1'b0;
    @(negedge clk);
    mode = 2'b11;
    @(posedge clk); #1;
    chk("R9 auto entry status", diag, 0);
  endtask

  // one period slice: toggle each input on its first n cycles,
  // optionally check rx_sel against the source in use
  task automatic run_cycles(input int cycles, input int nd, input int nt,
                            input int nc, input int src);
    for (int i = 0; i < cycles; i++) begin
      logic exp_bit;
      @(negedge clk);
      if (i < nd) d = ~d;
      if (i < nt) t = ~t;
      if (i < nc) c = ~c;
      exp_bit = (src == SRC_T) ? t : (src == SRC_C) ? c : d;
      @(posedge clk); #1;
      if (src != SRC_NONE) chk("R3 auto source follow", rx_sel, exp_bit);
    end
  endtask

  task automatic echo_rise(input logic tv, input logic cv);
    @(negedge clk);
    txd = 1'b0; t = 1'b0; c = 1'b0;
    @(negedge clk);
    txd = 1'b1; t = tv; c = cv;
    @(posedge clk); #1;
  endtask

  initial begin
    rst = 1'b1; d = 1'b1; t = 1'b1; c = 1'b1; txd = 1'b1; txa = 1'b0;
    mode = 2'b00; psel = 4'd0;
    repeat (3) @(posedge clk);
    #1;
    chk("R10 reset status", diag, 0);
    chk("R10 reset output", rx_sel, 1);
    @(negedge clk);
    rst = 1'b0;

    // R1 / R2: forced modes over every input combination
    for (int m = 0; m < 3; m++) begin
      @(negedge clk);
      mode = 2'(m);
      @(posedge clk); #1;
      for (int v = 0; v < 8; v++) begin
        logic exp_bit;
        @(negedge clk);
        {d, t, c} = 3'(v);
        exp_bit = (m == 0) ? d : (m == 1) ? c : t;
        @(posedge clk); #1;
        chk((m == 0) ? "R1 forced diff output" : "R2 forced wire output",
            rx_sel, exp_bit);
        chk((m == 0) ? "R1 forced status" : "R2 forced status", diag, m);
      end
    end

    // R8: echo mismatch ignored in forced modes
    @(negedge clk); mode = 2'b00; txa = 1'b1;
    echo_rise(1'b0, 1'b0);
    @(posedge clk); #1;
    chk("R8 echo ignored in mode 00", diag, 0);
    @(negedge clk); mode = 2'b10;
    echo_rise(1'b0, 1'b0);
    @(posedge clk); #1;
    chk("R8 echo ignored in mode 10", diag, 2);
    @(negedge clk); txa = 1'b0;

    // R5 / R6 / R3: edge-driven automatic selection, period 64
    enter_auto();
    run_cycles(BASE_LEN, 8, 8, 8, SRC_D);
    chk("R5 healthy diff keeps normal", diag, 0);
    run_cycles(BASE_LEN, 4, 0, 0, SRC_D);
    chk("R5 exactly 4 edges keeps normal", diag, 0);
    run_cycles(BASE_LEN, 3, 6, 5, SRC_D);
    chk("R5 3 edges gives major error", diag, 3);
    run_cycles(BASE_LEN, 0, 2, 5, SRC_D);
    chk("R6 major recovers on complement", diag, 1);
    run_cycles(BASE_LEN, 1, 0, 4, SRC_C);
    chk("R5 complement at 4 edges kept", diag, 1);
    run_cycles(BASE_LEN, 9, 9, 3, SRC_C);
    chk("R5 complement at 3 edges fails", diag, 3);
    run_cycles(BASE_LEN, 0, 3, 3, SRC_D);
    chk("R6 no wire healthy stays major", diag, 3);
    run_cycles(BASE_LEN, 0, 4, 7, SRC_D);
    chk("R6 true wire preferred", diag, 2);
    run_cycles(BASE_LEN, 1, 5, 0, SRC_T);
    chk("R5 true wire kept", diag, 2);

    // R9: mode change out of a degraded state
    @(negedge clk); mode = 2'b01;
    @(posedge clk); #1;
    chk("R9 mode change to forced", diag, 1);

    // R4: period length
    enter_auto();
    run_cycles(BASE_LEN - 1, 0, 0, 0, SRC_NONE);
    chk("R4 code 0 no end before 64", diag, 0);
    run_cycles(1, 0, 0, 0, SRC_NONE);
    chk("R4 code 0 ends at 64", diag, 3);
    psel = 4'd1;
    enter_auto();
    run_cycles(BASE_LEN, 0, 0, 0, SRC_NONE);
    chk("R4 code 1 no end at 64", diag, 0);
    run_cycles(BASE_LEN, 0, 0, 0, SRC_NONE);
    chk("R4 code 1 ends at 128", diag, 3);
    psel = 4'd7;
    enter_auto();
    run_cycles(8191, 0, 0, 0, SRC_NONE);
    chk("R4 code 7 no end before 8192", diag, 0);
    run_cycles(1, 0, 0, 0, SRC_NONE);
    chk("R4 code 7 ends at 8192", diag, 3);
    psel = 4'd0;

    // R7: echo decisions
    enter_auto(); txa = 1'b1;
    echo_rise(1'b1, 1'b0);
    chk("R7 comp mismatch selects true", diag, 2);
    echo_rise(1'b0, 1'b1);
    chk("R7 true mismatch in true state", diag, 3);
    enter_auto(); txa = 1'b1;
    echo_rise(1'b0, 1'b1);
    chk("R7 true mismatch selects comp", diag, 1);
    echo_rise(1'b1, 1'b0);
    chk("R7 comp mismatch in comp state", diag, 3);
    enter_auto(); txa = 1'b1;
    echo_rise(1'b0, 1'b0);
    chk("R7 both mismatch major", diag, 3);
    enter_auto(); txa = 1'b1;
    echo_rise(1'b1, 1'b1);
    chk("R7 matching echo keeps normal", diag, 0);

    // R8: echo ignored while not transmitting
    enter_auto(); txa = 1'b0;
    echo_rise(1'b0, 1'b0);
    chk("R8 echo ignored when idle", diag, 0);

    // R10: reset from major error
    txa = 1'b1;
    echo_rise(1'b0, 1'b0);
    chk("R7 setup major", diag, 3);
    @(negedge clk); rst = 1'b1; d = 1'b0;
    @(posedge clk); #1;
    chk("R10 reset clears status", diag, 0);
    chk("R10 reset output recessive", rx_sel, 1);
    @(negedge clk); rst = 1'b0;

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 190000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule